// File: doc/BRIEF.md
# Stuck-Bus SCL Recovery Pulse Generator

This block frees a two-wire serial bus that a target device holds low while it waits to clock out an acknowledge bit. On request it runs a fixed burst of nine SCL clock pulses. Each iteration starts with one cycle in which the controller is disabled. The controller is then enabled as a transmitting master and drives SCL low for one delay unit. It then drops back to plain enable and releases SCL for two delay units. SDA is never driven. A stuck target therefore sees enough clock edges to finish its bit and let go of the data line.

The delay unit, in microseconds, comes from the configured bus frequency in kHz: `1000 / f_khz + 1`, with a floor of 2. A small sequential divider computes it at the start of each burst. A programmable prescaler (`cyc_per_us`, system clock cycles per microsecond) turns microseconds into clock cycles. A burst starts from the `trig` input, or by itself once `bus_busy` has stayed high for `BUSY_TMO_US` microseconds in a row while the block is idle. The caller decides what else counts as a stuck bus.

The state machine has six states. IDLE waits for a request (IDLE→CALC on `trig` or busy timeout). CALC waits for the divider (CALC→OFF when the quotient is ready). OFF is the one-cycle disable step (OFF→PULL). PULL drives SCL low (PULL→REL after one unit). REL releases SCL (REL→OFF after two units while pulses remain, REL→DONE after the ninth). DONE raises `done` for one cycle (DONE→IDLE).

Top module: `scl_recovery_gen`

## Requirements
- R1: After reset `scl_low`, `sda_low`, `active` and `done` are all 0.
- R2: A 1 on `trig` sampled while idle starts a burst of exactly nine SCL pulses (`scl_low`=1 means the pin is pulled low).
- R3: The delay unit U in microseconds is max(2, floor(1000 / F) + 1), where F is `bus_khz`; a `bus_khz` of 0 is treated as 1.
- R4: Every pulse holds `scl_low`=1 for exactly U·C consecutive cycles, where C is `cyc_per_us` (0 treated as 1), sampled when the burst starts.
- R5: Between two consecutive pulses `scl_low` is 0 for exactly 2·U·C + 1 cycles: the two-unit release plus the one-cycle disable step.
- R6: `done` is 1 for exactly one cycle, immediately after the 2·U·C released cycles that follow the ninth pulse.
- R7: A `trig` that arrives while a burst is running is ignored: the burst still has nine pulses and no second burst follows.
- R8: `sda_low` stays 0 at all times, so SDA is only ever released.
- R9: With the block idle, `bus_busy` held high for BUSY_TMO_US·C consecutive cycles starts a burst. If `bus_busy` drops earlier, the count restarts and no burst starts.
- R10: `active` is 1 from the cycle after a request is accepted through the `done` cycle, and 0 in the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig | input | 1 | Recovery request, sampled while idle |
| bus_khz | input | FREQ_W | Configured bus frequency in kHz |
| cyc_per_us | input | CPU_W | System clock cycles per microsecond |
| bus_busy | input | 1 | Bus-busy indication for the idle timeout |
| scl_low | output | 1 | 1 = pull SCL low (open-drain enable) |
| sda_low | output | 1 | 1 = pull SDA low; always 0 |
| active | output | 1 | A recovery burst is in progress |
| done | output | 1 | One-cycle pulse when the burst completes |

## Verification
A wrong quotient or a wrong floor on the delay unit shows up on the very first pulse, as a low time different from U·C cycles. A miscounted iteration register shows up at the end of the burst, as eight or ten pulses before `done`. A phase counter that fails to clear shows up as gap lengths that drift from 2·U·C + 1 between pulses. A busy watchdog that does not restart appears either as a burst after a short busy window, or as a start cycle that differs from BUSY_TMO_US·C.

// File: rtl/rcv_pkg.sv
package rcv_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CALC,
        ST_OFF,
        ST_PULL,
        ST_REL,
        ST_DONE
    } rcv_state_e;
endpackage

// File: rtl/rcv_udiv.sv
// Sequential restoring divider: quo = NUM / den, one quotient bit per cycle.
module rcv_udiv #(
    parameter int NUM   = 1000,
    parameter int DEN_W = 11,
    parameter int QW    = $clog2(NUM + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DEN_W-1:0] den_in,
    output logic [QW-1:0]    quo,
    output logic             done_o
);
    localparam int IDXW = (QW > 1) ? $clog2(QW) : 1;
    localparam logic [QW-1:0] NUM_V = QW'(NUM);

    logic [DEN_W-1:0] den_r;
    logic [DEN_W-1:0] rem;
    logic [IDXW-1:0]  bit_idx;
    logic             run;
    logic [DEN_W:0]   trial;
    logic             ge;
    logic [DEN_W-1:0] rem_nx;

    always_comb begin
        trial  = {rem, NUM_V[bit_idx]};
        ge     = trial >= {1'b0, den_r};
        rem_nx = ge ? DEN_W'(trial - {1'b0, den_r}) : DEN_W'(trial);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            den_r   <= '0;
            rem     <= '0;
            quo     <= '0;
            bit_idx <= '0;
            run     <= 1'b0;
            done_o  <= 1'b0;
        end else if (start) begin
            den_r   <= (den_in == '0) ? DEN_W'(1) : den_in;
            rem     <= '0;
            quo     <= '0;
            bit_idx <= IDXW'(QW - 1);
            run     <= 1'b1;
            done_o  <= 1'b0;
        end else if (run) begin
            rem <= rem_nx;
            quo <= {quo[QW-2:0], ge};
            if (bit_idx == '0) begin
                run    <= 1'b0;
                done_o <= 1'b1;
            end else begin
                bit_idx <= bit_idx - 1'b1;
            end
        end else begin
            done_o <= 1'b0;
        end
    end

    AST_DIV_QUOTIENT: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ((32'(quo) * 32'(den_r) <= 32'(NUM)) &&
                    ((32'(quo) + 32'd1) * 32'(den_r) > 32'(NUM)))); // R3
endmodule

// File: rtl/rcv_busy_watch.sv
// Counts consecutive busy microseconds while armed; flags expiry.
module rcv_busy_watch #(
    parameter int CPU_W  = 8,
    parameter int TMO_US = 1000000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             bus_busy,
    input  logic [CPU_W-1:0] cpu,
    output logic             hit
);
    localparam int TW = $clog2(TMO_US + 1);

    logic [CPU_W-1:0] pre;
    logic [TW-1:0]    us;
    logic             counting;
    logic             us_tick;

    assign counting = arm && bus_busy;
    assign us_tick  = (pre == cpu - 1'b1);
    assign hit      = counting && us_tick && (us == TW'(TMO_US - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre <= '0;
            us  <= '0;
        end else if (!counting || hit) begin
            pre <= '0;
            us  <= '0;
        end else if (us_tick) begin
            pre <= '0;
            us  <= us + 1'b1;
        end else begin
            pre <= pre + 1'b1;
        end
    end

    AST_BUSY_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_busy |=> (us == '0 && pre == '0)); // R9
    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        us <= TW'(TMO_US - 1)); // R9
endmodule

// File: rtl/scl_recovery_gen.sv
module scl_recovery_gen
    import rcv_pkg::*;
#(
    parameter int FREQ_W      = 11,
    parameter int CPU_W       = 8,
    parameter int NUM_KHZ     = 1000,
    parameter int PULSES      = 9,
    parameter int BUSY_TMO_US = 1000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  logic [FREQ_W-1:0] bus_khz,
    input  logic [CPU_W-1:0]  cyc_per_us,
    input  logic              bus_busy,
    output logic              scl_low,
    output logic              sda_low,
    output logic              active,
    output logic              done
);
    localparam int QW = $clog2(NUM_KHZ + 1);
    localparam int UW = QW + 1;
    localparam int PW = UW + 1;
    localparam int IW = $clog2(PULSES + 1);

    rcv_state_e       state, state_nx;
    logic [CPU_W-1:0] cpu_eff, cpu_r;
    logic [UW-1:0]    unit_r, unit_calc, q_plus;
    logic [CPU_W-1:0] pre;
    logic [PW-1:0]    us_cnt;
    logic [IW-1:0]    iter;
    logic             tmo_hit, go, tick, pull_end, rel_end;
    logic [QW-1:0]    quo;
    logic             div_done;

    assign cpu_eff = (cyc_per_us == '0) ? CPU_W'(1) : cyc_per_us;
    assign go      = (state == ST_IDLE) && (trig || tmo_hit);

    rcv_udiv #(.NUM(NUM_KHZ), .DEN_W(FREQ_W), .QW(QW)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (go),
        .den_in (bus_khz),
        .quo    (quo),
        .done_o (div_done)
    );

    rcv_busy_watch #(.CPU_W(CPU_W), .TMO_US(BUSY_TMO_US)) u_watch (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (state == ST_IDLE),
        .bus_busy (bus_busy),
        .cpu      (cpu_eff),
        .hit      (tmo_hit)
    );

    always_comb begin
        q_plus    = UW'(quo) + UW'(1);
        unit_calc = (q_plus < UW'(2)) ? UW'(2) : q_plus;
    end

    assign tick     = (pre == cpu_r - 1'b1);
    assign pull_end = tick && (us_cnt == PW'(unit_r) - PW'(1));
    assign rel_end  = tick && (us_cnt == {unit_r, 1'b0} - PW'(1));

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (go)       state_nx = ST_CALC;
            ST_CALC: if (div_done) state_nx = ST_OFF;
            ST_OFF:                state_nx = ST_PULL;
            ST_PULL: if (pull_end) state_nx = ST_REL;
            ST_REL:  if (rel_end)  state_nx = (iter == IW'(PULSES - 1)) ? ST_DONE : ST_OFF;
            ST_DONE:               state_nx = ST_IDLE;
            default:               state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpu_r  <= CPU_W'(1);
            unit_r <= UW'(2);
            pre    <= '0;
            us_cnt <= '0;
            iter   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    iter <= '0;
                    if (go) cpu_r <= cpu_eff;
                end
                ST_CALC: begin
                    if (div_done) unit_r <= unit_calc;
                end
                ST_OFF: begin
                    pre    <= '0;
                    us_cnt <= '0;
                end
                ST_PULL, ST_REL: begin
                    if (tick) begin
                        pre <= '0;
                        if ((state == ST_PULL && pull_end) || (state == ST_REL && rel_end))
                            us_cnt <= '0;
                        else
                            us_cnt <= us_cnt + 1'b1;
                        if (state == ST_REL && rel_end && iter != IW'(PULSES - 1))
                            iter <= iter + 1'b1;
                    end else begin
                        pre <= pre + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        scl_low = (state == ST_PULL);
        sda_low = 1'b0;
        active  = (state != ST_IDLE);
        done    = (state == ST_DONE);
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (iter == IW'(PULSES - 1))); // R2
    AST_ITER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        iter <= IW'(PULSES - 1)); // R2
    AST_PULL_AFTER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_low) |-> ($past(state) == ST_OFF)); // R5
    AST_PULL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_low) |-> ($past(us_cnt) == PW'(unit_r) - PW'(1))); // R4
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PULL || state == ST_REL) |=> (iter >= $past(iter))); // R7
    AST_UNIT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        unit_r >= UW'(2)); // R3
    AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !active); // R10
endmodule

// File: tb/scl_recovery_gen_bench.sv
module scl_recovery_gen_bench;
    localparam int TMO = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig = 1'b0;
    logic [10:0] bus_khz = 11'd400;
    logic [7:0]  cyc_per_us = 8'd1;
    logic        bus_busy = 1'b0;
    logic        scl_low, sda_low, active, done;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    scl_recovery_gen #(.BUSY_TMO_US(TMO)) u_scl_recovery_gen (
        .clk(clk), .rst_n(rst_n), .trig(trig), .bus_khz(bus_khz),
        .cyc_per_us(cyc_per_us), .bus_busy(bus_busy), .scl_low(scl_low),
        .sda_low(sda_low), .active(active), .done(done)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc >= 190000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: act cycles=%0d exp < 190000", cyc);
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_cycles(input int khz, input int cpu);
        int f, q, u, c;
        f = (khz == 0) ? 1 : khz;
        q = 1000 / f;
        u = (q + 1 < 2) ? 2 : q + 1;
        c = (cpu == 0) ? 1 : cpu;
        return u * c;
    endfunction

    // Runs one burst; retrig_at > 0 pulses trig at that sample index.
    task automatic run_burst(input int khz, input int cpu, input int retrig_at);
        int d, pulses, run_len, gap, n;
        bit prev, seen_done, inactive;
        d = exp_cycles(khz, cpu);
        pulses = 0; run_len = 0; gap = 0; prev = 1'b0; seen_done = 1'b0; inactive = 1'b0;
        @(negedge clk);
        bus_khz = 11'(khz);
        cyc_per_us = 8'(cpu);
        trig = 1'b1;
        for (n = 1; n <= 60000 && !seen_done; n++) begin
            @(negedge clk);
            trig = (n == retrig_at) ? 1'b1 : 1'b0;
            if (sda_low) chk(1'b0, "R8 sda driven", 1, 0);
            if (!active) inactive = 1'b1;
            if (done) begin
                seen_done = 1'b1;
                chk(pulses == 9, "R2 pulse count", pulses, 9);
                chk(gap == 2 * d, "R6 done latency", gap, 2 * d);
            end else if (scl_low) begin
                if (!prev) begin
                    if (pulses > 0) chk(gap == 2 * d + 1, "R5 gap length", gap, 2 * d + 1);
                    pulses = pulses + 1;
                    run_len = 1;
                end else begin
                    run_len = run_len + 1;
                end
                prev = 1'b1;
            end else begin
                if (prev) begin
                    chk(run_len == d, "R4 R3 pulse width", run_len, d);
                    gap = 1;
                end else begin
                    gap = gap + 1;
                end
                prev = 1'b0;
            end
        end
        trig = 1'b0;
        chk(seen_done, "R6 done seen", int'(seen_done), 1);
        chk(!inactive, "R10 active during burst", int'(inactive), 0);
        @(negedge clk);
        chk(!done && !active, "R10 idle after done", int'({done, active}), 0);
        if (retrig_at > 0) begin
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (active) begin
                    chk(1'b0, "R7 retrigger started burst", 1, 0);
                    break;
                end
            end
            chk(!active, "R7 no second burst", int'(active), 0);
        end
    endtask

    initial begin
        int khz_list [7] = '{1000, 1500, 400, 333, 250, 100, 7};
        int first;
        repeat (3) @(negedge clk);
        chk(!scl_low && !sda_low && !active && !done, "R1 reset outputs",
            int'({scl_low, sda_low, active, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!active && !scl_low, "R1 idle after reset", int'({active, scl_low}), 0);

        for (int i = 0; i < 7; i++)
            for (int c = 0; c < 4; c++)
                run_burst(khz_list[i], c, 0);
        run_burst(0, 1, 0);
        run_burst(400, 2, 7);
        run_burst(1000, 1, 3);

        // R9: short busy window does not fire
        @(negedge clk);
        cyc_per_us = 8'd2; bus_khz = 11'd1000;
        bus_busy = 1'b1;
        repeat (TMO * 2 - 1) @(negedge clk);
        bus_busy = 1'b0;
        first = 0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (active) first = 1;
        end
        chk(first == 0, "R9 short busy ignored", first, 0);

        // R9: full busy window starts a burst at sample TMO*cpu
        bus_busy = 1'b1;
        first = 0;
        for (int k = 1; k <= 100 && first == 0; k++) begin
            @(negedge clk);
            if (active) first = k;
        end
        chk(first == TMO * 2, "R9 busy timeout start", first, TMO * 2);
        bus_busy = 1'b0;
        for (int k = 0; k < 2000 && !done; k++) @(negedge clk);
        chk(done, "R9 R6 busy burst done", int'(done), 1);
        repeat (3) @(negedge clk);

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule